// File: doc/BRIEF.md
# Scrolling Seven-Segment Message Display

This block drives a four-digit, time-multiplexed seven-segment display. It shows a window onto a fixed message of eight 4-bit character codes. The window moves along the message by one character each second. Everything runs on one system clock. A first divider turns that clock into a one-cycle refresh enable at about 1 kHz. A second divider counts refresh enables and turns them into a one-cycle scroll enable at about 1 Hz.

On every scroll enable the message store rotates by one position. Entries 4 to 7 of the store feed digits 0 to 3. The digit scanner lights one digit per refresh enable, in the order 0, 1, 2, 3, and then repeats. It captures that digit's character code at the moment the digit is selected and decodes the code to a hexadecimal glyph. The message content is a parameter. The dividers are parameters too, so a bench can run them with small ratios.

Top module: `scroll_seg_display`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to its reset state at that edge. In this state all four `dig_n` bits are 1 (blank) and all seven `seg_n` bits are 1. The message returns to `MSG_INIT`, and both divider counts and both enables are cleared.
- R2: After reset is released, the internal refresh enable is high for exactly one cycle in every `REFRESH_DIV` system cycles. It first goes high after the `REFRESH_DIV`-th rising edge.
- R3: The scroll enable is high for one cycle after every `SCROLL_DIV` refresh enables. It rises in the cycle that follows the refresh enable that completes the count.
- R4: Entry i of the message store starts as bits [4i+3:4i] of `MSG_INIT`. The default value 32'h1234_5670 puts codes 1,2,3,4,5,6,7,0 in entries 7 down to 0. On each scroll enable, entry 7 moves to entry 0 and every other entry moves up by one index. No code is lost or changed.
- R5: Digits 0, 1, 2 and 3 show message entries 4, 5, 6 and 7.
- R6: `dig_n` is active-low and has at most one bit low; bit d selects digit d. Each refresh enable moves the selection to the next digit in the order 0,1,2,3,0,… The first refresh enable after reset selects digit 0. `dig_n` and `seg_n` change in the cycle after a refresh enable and hold their values at all other times.
- R7: `seg_n` is active-low, with bit 0 = segment a through bit 6 = segment g. The lit segment sets are as follows. Code 0 lights abcdef and 1 lights bc. Code 2 lights abdeg and 3 lights abcdg. Code 4 lights bcfg and 5 lights acdfg. Code 6 lights acdefg and 7 lights abc. Code 8 lights all seven and 9 lights abcdfg. Code A lights abcefg and b lights cdefg. Code C lights adef and d lights bcdeg. Code E lights adefg and F lights aefg.
- R8: A digit's code is captured when that digit is selected. A scroll in the middle of a refresh period changes the display only from the next selected digit onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_n | output | 7 | Segment drives a..g in bits 0..6, active low |
| dig_n | output | 4 | Digit selects 0..3, active low, at most one low |

## Verification
The checker assertions hold on every cycle. They cover the spacing of the refresh and scroll enables, measured by the checker's own counters. They also cover the rotation of the store on a scroll enable, the fact that it holds still otherwise, and the restored message after reset. Finally they cover the one-hot digit select and the rule that outputs hold between refresh enables. Some behaviour only the bench can show by comparing with its timing model: which character lands on which digit, the exact glyph for each code, and the one-digit delay before a scroll appears. The bench builds two instances with different ratios and messages so that all sixteen codes are decoded.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Active-low glyph, bit 0 = segment a ... bit 6 = segment g.
  function automatic seg_t glyph_n(input code_t c);
    seg_t lit;
    case (c)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction

  // Wrapping increment of a scan index.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned limit);
    return (v >= limit - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/ssd_tick_div.sv
module ssd_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap)    cnt_q <= '0;
      else if (en) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssd_msg_ring.sv
module ssd_msg_ring #(
  parameter int ENTRIES = 8,
  parameter int CW      = 4,
  parameter int SHOWN   = 4,
  parameter logic [ENTRIES*CW-1:0] INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step,
  output logic [ENTRIES*CW-1:0] ring,
  output logic [SHOWN*CW-1:0]   window
);
  localparam int W    = ENTRIES * CW;
  localparam int BASE = ENTRIES - SHOWN;

  logic [W-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst)       ring_q <= INIT;
    else if (step) ring_q <= {ring_q[W-CW-1:0], ring_q[W-1:W-CW]};
  end

  assign ring = ring_q;

  for (genvar d = 0; d < SHOWN; d++) begin : g_win
    assign window[d*CW +: CW] = ring_q[(BASE+d)*CW +: CW];
  end
endmodule

// File: rtl/ssd_digit_scan.sv
module ssd_digit_scan
  import ssd_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic [DIGITS*CODE_W-1:0] window,
  output logic [DIGITS-1:0]        dig_n,
  output logic [SEG_W-1:0]         seg_n
);
  localparam int IW = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nxt;
  code_t         pick;

  assign idx_nxt = IW'(wrap_inc(int'(idx_q), DIGITS));
  assign pick    = window[idx_nxt*CODE_W +: CODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= IW'(DIGITS - 1);
      dig_n <= '1;
      seg_n <= '1;
    end else if (adv) begin
      idx_q <= idx_nxt;
      dig_n <= ~(DIGITS'(1) << idx_nxt);
      seg_n <= glyph_n(pick);
    end
  end
endmodule

// File: rtl/scroll_seg_display.sv
module scroll_seg_display
  import ssd_pkg::*;
#(
  parameter int REFRESH_DIV = 50000,
  parameter int SCROLL_DIV  = 1000,
  parameter int NUM_CHARS   = 8,
  parameter int NUM_DIGITS  = 4,
  parameter logic [NUM_CHARS*4-1:0] MSG_INIT = 32'h1234_5670
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [SEG_W-1:0]      seg_n,
  output logic [NUM_DIGITS-1:0] dig_n
);
  localparam int RING_W = NUM_CHARS * CODE_W;
  localparam int WIN_W  = NUM_DIGITS * CODE_W;

  logic              refresh_tick;
  logic              scroll_tick;
  logic [RING_W-1:0] ring_flat;
  logic [WIN_W-1:0]  window;

  ssd_tick_div #(.DIV(REFRESH_DIV)) u_refresh (
    .clk(clk), .rst(rst), .en(1'b1), .tick(refresh_tick)
  );

  ssd_tick_div #(.DIV(SCROLL_DIV)) u_scroll (
    .clk(clk), .rst(rst), .en(refresh_tick), .tick(scroll_tick)
  );

  ssd_msg_ring #(
    .ENTRIES(NUM_CHARS), .CW(CODE_W), .SHOWN(NUM_DIGITS), .INIT(MSG_INIT)
  ) u_ring (
    .clk(clk), .rst(rst), .step(scroll_tick), .ring(ring_flat), .window(window)
  );

  ssd_digit_scan #(.DIGITS(NUM_DIGITS)) u_scan (
    .clk(clk), .rst(rst), .adv(refresh_tick), .window(window),
    .dig_n(dig_n), .seg_n(seg_n)
  );
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
  parameter int REFRESH_DIV = 4,
  parameter int SCROLL_DIV  = 4,
  parameter int RING_W      = 32,
  parameter int DIGITS      = 4,
  parameter logic [RING_W-1:0] MSG_INIT = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              refresh_tick,
  input logic              scroll_tick,
  input logic [RING_W-1:0] ring_flat,
  input logic [6:0]        seg_n,
  input logic [DIGITS-1:0] dig_n
);
  localparam int PW = $clog2(REFRESH_DIV + 1);
  localparam int SW = $clog2(SCROLL_DIV + 1);

  logic [PW-1:0] per_cnt;
  logic [SW-1:0] ref_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0;
      ref_cnt <= '0;
    end else begin
      per_cnt <= refresh_tick ? PW'(1) : per_cnt + 1'b1;
      if (scroll_tick)       ref_cnt <= '0;
      else if (refresh_tick) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  AST_RESET_MSG: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ring_flat == MSG_INIT && dig_n == '1 && seg_n == '1)); // R1

  AST_REFRESH_PERIOD: assert property (@(posedge clk) disable iff (rst)
    refresh_tick |-> per_cnt == PW'(REFRESH_DIV)); // R2

  AST_REFRESH_BOUND: assert property (@(posedge clk) disable iff (rst)
    per_cnt <= PW'(REFRESH_DIV)); // R2

  AST_SCROLL_COUNT: assert property (@(posedge clk) disable iff (rst)
    scroll_tick |-> ref_cnt == SW'(SCROLL_DIV)); // R3

  AST_SCROLL_AFTER_REFRESH: assert property (@(posedge clk) disable iff (rst)
    scroll_tick |-> $past(refresh_tick)); // R3

  AST_RING_ROTATE: assert property (@(posedge clk) disable iff (rst)
    scroll_tick |=> ring_flat == {$past(ring_flat[RING_W-5:0]), $past(ring_flat[RING_W-1:RING_W-4])}); // R4

  AST_RING_HOLD: assert property (@(posedge clk) disable iff (rst)
    !scroll_tick |=> $stable(ring_flat)); // R4

  AST_DIG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_n)); // R6

  AST_DIG_LIT_AFTER_REFRESH: assert property (@(posedge clk) disable iff (rst)
    refresh_tick |=> $countones(~dig_n) == 1); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !refresh_tick |=> ($stable(dig_n) && $stable(seg_n))); // R6
endmodule

bind scroll_seg_display ssd_checker #(
  .REFRESH_DIV(REFRESH_DIV), .SCROLL_DIV(SCROLL_DIV),
  .RING_W(RING_W), .DIGITS(NUM_DIGITS), .MSG_INIT(MSG_INIT)
) u_chk (
  .clk(clk), .rst(rst), .refresh_tick(refresh_tick), .scroll_tick(scroll_tick),
  .ring_flat(ring_flat), .seg_n(seg_n), .dig_n(dig_n)
);

// File: tb/tb_scroll_seg_display.sv
module tb_scroll_seg_display;
  localparam int CLK_PERIOD = 10;
  localparam int R_A = 3, S_A = 4;
  localparam logic [31:0] M_A = 32'h1234_5670;
  localparam int R_B = 2, S_B = 3;
  localparam logic [31:0] M_B = 32'hFEDC_BA98;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] seg_a, seg_b;
  logic [3:0] dig_a, dig_b;
  int unsigned t = 0;
  int unsigned cycles = 0;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scroll_seg_display #(.REFRESH_DIV(R_A), .SCROLL_DIV(S_A), .MSG_INIT(M_A)) dut (
    .clk(clk), .rst(rst), .seg_n(seg_a), .dig_n(dig_a));
  scroll_seg_display #(.REFRESH_DIV(R_B), .SCROLL_DIV(S_B), .MSG_INIT(M_B)) dut2 (
    .clk(clk), .rst(rst), .seg_n(seg_b), .dig_n(dig_b));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) t <= 0;
    else     t <= t + 1;
  end

  // Per-segment sets of lit codes (bit c set = code c lights that segment).
  function automatic logic [6:0] seg_model(input logic [3:0] code);
    logic [15:0] m;
    logic [6:0]  r;
    for (int s = 0; s < 7; s++) begin
      case (s)
        0: m = 16'hD7ED;
        1: m = 16'h279F;
        2: m = 16'h2FFB;
        3: m = 16'h7B6D;
        4: m = 16'hFD45;
        5: m = 16'hDF71;
        default: m = 16'hEF7C;
      endcase
      r[s] = ~m[code];
    end
    return r;
  endfunction

  // Expected {dig_n, seg_n} t edges after reset release.
  function automatic logic [10:0] model(input int unsigned tt, input int r,
                                        input int s, input logic [31:0] msg);
    int unsigned m, d, k, idx;
    if (tt < r + 1) return 11'h7FF;
    m   = (tt - 1) / r;          // refresh enables seen so far
    d   = (m - 1) % 4;           // digit shown
    k   = (m - 1) / s;           // scrolls applied before capture
    idx = (4 + d + 8 - (k % 8)) % 8;
    return {~(4'b0001 << d), seg_model(msg[idx*4 +: 4])};
  endfunction

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0d actual=%h expected=%h", tag, t, act, exp);
    end
  endtask

  task automatic run_episode(input int hold, input int len);
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R1 dut", {dig_a, seg_a}, 11'h7FF);
      chk("R1 dut2", {dig_b, seg_b}, 11'h7FF);
    end
    rst = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      // R2 R3 R4 R5 R6 R7 R8 via timing model
      chk("R2 R3 R4 R5 R6 R7 R8 dut", {dig_a, seg_a}, model(t, R_A, S_A, M_A));
      chk("R2 R3 R4 R5 R6 R7 R8 dut2", {dig_b, seg_b}, model(t, R_B, S_B, M_B));
    end
  endtask

  initial begin
    void'($urandom(32'd20130509));
    // Directed: long run covering several full message wraps (R4).
    run_episode(2, 260);
    // Directed: reset lands just before the first refresh enable (R1).
    run_episode(1, R_A);
    // Directed: reset straight after a scroll boundary (R8 corner).
    run_episode(3, R_A * S_A + 2);
    // Random reset lengths and run lengths.
    for (int e = 0; e < 8; e++)
      run_episode(1 + int'($urandom % 3), 20 + int'($urandom % 180));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule